// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

The block holds two 8-bit up-counters that share one free-running prescaler. Each channel picks its own count source: one of seven fixed divisions of the block clock (/1, /2, /8, /32, /64, /1024, /8192) or a rising edge on an external count input. Each channel has two compare registers. Compare A can restart the count, which sets the period. Compare B then sets the duty point or the toggle point, so each channel can drive either a toggling pulse output or a PWM waveform.

The upper channel (channel 1) can be chained behind the lower one (channel 0). In that mode the pair counts as one 16-bit timer. Compare-match and overflow events raise sticky flags, and software clears them with a write. All state is reached through a small register port with eight byte-wide registers. Reads are combinational from the address.

Top module: `dual_timer8`

## Requirements
- R1: After reset, every control and count register reads 0x00, both compare registers of both channels read 0xFF, and all flags and both wave outputs are 0.
- R2: The address is {channel, reg}: reg 0 is control, reg 1 is count, reg 2 is compare A and reg 3 is compare B. Control reads back as {0, run[6], clr_on_a[5], pwm[4], cascade[3], sel[2:0]}. The cascade bit exists only in channel 1 and reads 0 in channel 0. Writing control bit 7 is not stored.
- R3: Select codes 0 to 6 give one count step every 1, 2, 8, 32, 64, 1024 and 8192 clock cycles. Any window of clock edges whose length is a multiple of the ratio holds exactly length/ratio steps.
- R4: Select code 7 counts rising edges of ext_clk, one step per edge, after a two-flop synchronizer.
- R5: A channel whose run bit is 0 and which is not cascaded holds its count.
- R6: A step taken at count 0xFF wraps the count to 0x00 and sets that channel's overflow flag, unless clear-on-A restarts it first.
- R7: A step taken while count equals compare A sets the compare-A flag. If clr_on_a is 1, that step loads 0x00 in place of the increment.
- R8: A step taken while count equals compare B sets the compare-B flag. In pulse mode (pwm=0) it toggles the channel's wave output.
- R9: In PWM mode a compare-A step drives the output high and a compare-B step drives it low. When both match on the same step, low wins.
- R10: With cascade set, channel 1 steps exactly when channel 0 overflows, and its own select and run bits are ignored.
- R11: Flags stay set until control is written with bit 7 = 1, which clears all three flags of that channel.
- R12: A write to a count register takes priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address {channel, reg} |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| ext_clk | input | 1 | External count input, asynchronous |
| wave_out | output | 2 | Waveform output per channel |
| flag_cma | output | 2 | Sticky compare-A flag per channel |
| flag_cmb | output | 2 | Sticky compare-B flag per channel |
| flag_ovf | output | 2 | Sticky overflow flag per channel |

## Verification
The assertions watch properties that hold on every cycle. A count changes only by +1 or by a restart to zero. A stopped lower channel holds still. A cascaded upper channel moves only on the edge where the lower one wraps from 0xFF. A flag falls only after a clear write. The exact ratio of each prescale code, synchronized counting of external edges, the duty and period of the PWM and pulse waveforms, and the write-over-step priority depend on the history of a whole run. Only the directed scenarios of the bench can show those.

// File: rtl/dual_timer8.sv
module dual_timer8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_clk,
  output logic [1:0] wave_out,
  output logic [1:0] flag_cma,
  output logic [1:0] flag_cmb,
  output logic [1:0] flag_ovf
);
  localparam int PW = 13;

  logic [PW-1:0] pre;
  logic [2:0]    ext_q;
  logic [6:0]    ctl [2];
  logic [7:0]    cnt [2];
  logic [7:0]    cpa [2];
  logic [7:0]    cpb [2];
  logic          ext_rise, tk0, tk1, wrap0;
  logic [1:0]    tk, ha, hb, ov, fclr;

  function automatic logic src_tick(input logic [2:0] sel, input logic [PW-1:0] p, input logic ex);
    case (sel)
      3'd0:    return 1'b1;
      3'd1:    return p[0];
      3'd2:    return &p[2:0];
      3'd3:    return &p[4:0];
      3'd4:    return &p[5:0];
      3'd5:    return &p[9:0];
      3'd6:    return &p[12:0];
      default: return ex;
    endcase
  endfunction

  assign ext_rise = ext_q[1] & ~ext_q[2];
  assign tk0      = ctl[0][6] & src_tick(ctl[0][2:0], pre, ext_rise);
  assign wrap0    = tk0 && cnt[0] == 8'hFF && !(ctl[0][5] && cnt[0] == cpa[0]);
  assign tk1      = ctl[1][3] ? wrap0 : (ctl[1][6] & src_tick(ctl[1][2:0], pre, ext_rise));
  assign tk       = {tk1, tk0};

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      ha[c]   = tk[c] && cnt[c] == cpa[c];
      hb[c]   = tk[c] && cnt[c] == cpb[c];
      ov[c]   = tk[c] && cnt[c] == 8'hFF && !(ctl[c][5] && ha[c]);
      fclr[c] = wr_en && addr == {1'(c), 2'd0} && wdata[7];
    end
  end

  always_comb begin
    case (addr[1:0])
      2'd0:    rdata = {1'b0, ctl[addr[2]]};
      2'd1:    rdata = cnt[addr[2]];
      2'd2:    rdata = cpa[addr[2]];
      default: rdata = cpb[addr[2]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre      <= '0;
      ext_q    <= '0;
      wave_out <= '0;
      flag_cma <= '0;
      flag_cmb <= '0;
      flag_ovf <= '0;
      for (int c = 0; c < 2; c++) begin
        ctl[c] <= '0;
        cnt[c] <= '0;
        cpa[c] <= 8'hFF;
        cpb[c] <= 8'hFF;
      end
    end else begin
      pre   <= pre + 1'b1;
      ext_q <= {ext_q[1:0], ext_clk};
      for (int c = 0; c < 2; c++) begin
        if (wr_en && addr == {1'(c), 2'd0})
          ctl[c] <= (c == 0) ? {wdata[6:4], 1'b0, wdata[2:0]} : wdata[6:0];
        if (wr_en && addr == {1'(c), 2'd2}) cpa[c] <= wdata;
        if (wr_en && addr == {1'(c), 2'd3}) cpb[c] <= wdata;
        if (wr_en && addr == {1'(c), 2'd1})
          cnt[c] <= wdata;
        else if (tk[c])
          cnt[c] <= (ctl[c][5] && ha[c]) ? 8'h00 : cnt[c] + 8'd1;
        flag_cma[c] <= (flag_cma[c] & ~fclr[c]) | ha[c];
        flag_cmb[c] <= (flag_cmb[c] & ~fclr[c]) | hb[c];
        flag_ovf[c] <= (flag_ovf[c] & ~fclr[c]) | ov[c];
        if (tk[c]) begin
          if (ctl[c][4]) begin
            if (hb[c])      wave_out[c] <= 1'b0;
            else if (ha[c]) wave_out[c] <= 1'b1;
          end else if (hb[c]) begin
            wave_out[c] <= ~wave_out[c];
          end
        end
      end
    end
  end
endmodule

module dual_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] c0,
  input logic [7:0] c1,
  input logic [6:0] k0,
  input logic [6:0] k1,
  input logic [1:0] fa,
  input logic [1:0] fb,
  input logic [1:0] fo
);
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en && addr == 3'd1) && c0 != $past(c0)) |-> (c0 == $past(c0) + 8'd1 || c0 == 8'h00));

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(k0[6]) && !$past(wr_en && addr == 3'd1)) |-> c0 == $past(c0));

  a_r10_upper_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(k1[3]) && !$past(wr_en && addr == 3'd5) && !$past(wr_en && addr == 3'd1) && c1 != $past(c1))
      |-> (c0 == 8'h00 && $past(c0) == 8'hFF));

  for (genvar i = 0; i < 2; i++) begin : g_flag
    a_r11_cma_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fa[i]) |-> $past(wr_en && addr == {1'(i), 2'd0} && wdata[7]));
    a_r11_cmb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fb[i]) |-> $past(wr_en && addr == {1'(i), 2'd0} && wdata[7]));
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fo[i]) |-> $past(wr_en && addr == {1'(i), 2'd0} && wdata[7]));
  end
endmodule

bind dual_timer8 dual_timer8_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .c0(cnt[0]), .c1(cnt[1]), .k0(ctl[0]), .k1(ctl[1]),
  .fa(flag_cma), .fb(flag_cmb), .fo(flag_ovf)
);

// File: tb/dual_timer8_test.sv
module dual_timer8_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic       ext_clk = 0;
  logic [7:0] rdata;
  logic [1:0] wave_out, flag_cma, flag_cmb, flag_ovf;
  int total = 0;
  int bad = 0;

  dual_timer8 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ext_clk(ext_clk), .wave_out(wave_out), .flag_cma(flag_cma), .flag_cmb(flag_cmb), .flag_ovf(flag_ovf)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic window(input logic [2:0] ca, input logic [7:0] c, input int steps);
    wr(ca, c | 8'h40);
    idle(steps - 2);
    wr(ca, c & 8'hBF);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, (a % 4 >= 2) ? 8'hFF : 8'h00);
    end
    check("R1 reset outputs", {wave_out, flag_cma, flag_cmb, flag_ovf}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd0, 8'hBD); rd(3'd0, v); check("R2 ch0 control, no cascade bit", v, 8'h35);
    wr(3'd4, 8'h8F); rd(3'd4, v); check("R2 ch1 control with cascade", v, 8'h0F);
    wr(3'd6, 8'h5A); rd(3'd6, v); check("R2 ch1 compare A", v, 8'h5A);
    wr(3'd3, 8'hC3); rd(3'd3, v); check("R2 ch0 compare B", v, 8'hC3);
    wr(3'd0, 8'h80); wr(3'd4, 8'h80);
    wr(3'd3, 8'hFF); wr(3'd6, 8'hFF);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    int ratio [7] = '{1, 2, 8, 32, 64, 1024, 8192};
    int steps [7] = '{5, 20, 40, 64, 128, 2048, 8192};
    wr(3'd5, 8'h33);
    for (int s = 0; s < 7; s++) begin
      wr(3'd1, 8'h00);
      window(3'd0, 8'(s), steps[s]);
      rd(3'd1, v);
      check($sformatf("R3 select %0d", s), v, steps[s] / ratio[s]);
    end
    rd(3'd5, v); check("R5 stopped ch1 holds", v, 8'h33);
  endtask

  task automatic t_external();
    logic [7:0] v;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h47);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ext_clk = 1; idle(3);
      @(negedge clk); ext_clk = 0; idle(3);
    end
    idle(5);
    wr(3'd0, 8'h07);
    rd(3'd1, v); check("R4 external rising edges", v, 4);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(3'd0, 8'h80); wr(3'd2, 8'h10); wr(3'd1, 8'hFE);
    window(3'd0, 8'h00, 3);
    rd(3'd1, v); check("R6 wrap count", v, 8'h01);
    check("R6 overflow flag", flag_ovf[0], 1);
    check("R7 no compare A hit", flag_cma[0], 0);
    idle(20);
    check("R11 flag stays set", flag_ovf[0], 1);
    wr(3'd0, 8'h80);
    check("R11 clear write", {flag_cma[0], flag_cmb[0], flag_ovf[0]}, 0);
  endtask

  task automatic t_clear_a();
    logic [7:0] v;
    wr(3'd0, 8'h80); wr(3'd2, 8'h04); wr(3'd1, 8'h00);
    window(3'd0, 8'h20, 7);
    rd(3'd1, v); check("R7 restart on compare A", v, 8'h02);
    check("R7 compare A flag", flag_cma[0], 1);
    check("R6 no overflow on restart", flag_ovf[0], 0);
  endtask

  task automatic t_pulse();
    int highs = 0, changes = 0;
    logic prev;
    wr(3'd4, 8'h80); wr(3'd6, 8'h03); wr(3'd7, 8'h02); wr(3'd5, 8'h00);
    wr(3'd4, 8'h60);
    idle(8);
    prev = wave_out[1];
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (wave_out[1]) highs++;
      if (wave_out[1] != prev) changes++;
      prev = wave_out[1];
    end
    wr(3'd4, 8'h20);
    check("R8 pulse high time", highs, 8);
    check("R8 pulse toggles", changes, 4);
    check("R8 compare B flag", flag_cmb[1], 1);
  endtask

  task automatic t_pwm(input logic [7:0] a, input logic [7:0] b, input int exp_high, input string req);
    int highs = 0;
    wr(3'd2, a); wr(3'd3, b); wr(3'd1, 8'h00);
    wr(3'd0, 8'h70);
    idle(8);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (wave_out[0]) highs++;
    end
    wr(3'd0, 8'h30);
    check(req, highs, exp_high);
  endtask

  task automatic t_cascade();
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd2, 8'h10); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h8F);
    wr(3'd1, 8'hFE); wr(3'd5, 8'h05);
    idle(6);
    rd(3'd5, v); check("R10 upper ignores own select", v, 8'h05);
    window(3'd0, 8'h00, 3);
    rd(3'd1, v); check("R10 lower after wrap", v, 8'h01);
    rd(3'd5, v); check("R10 upper stepped once", v, 8'h06);
    wr(3'd1, 8'hFE); wr(3'd5, 8'hFF);
    window(3'd0, 8'h00, 3);
    rd(3'd5, v); check("R10 upper wraps", v, 8'h00);
    check("R10 upper overflow flag", flag_ovf[1], 1);
    wr(3'd4, 8'h80);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    wr(3'd0, 8'h80); wr(3'd2, 8'hF0); wr(3'd1, 8'h00);
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h40);
    wr(3'd0, 8'h00);
    rd(3'd1, v); check("R12 write beats step", v, 8'h42);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    t_reset();
    t_regs();
    t_prescale();
    t_external();
    t_overflow();
    t_clear_a();
    t_pulse();
    t_pwm(8'h03, 8'h01, 8, "R9 pwm duty");
    t_pwm(8'h02, 8'h02, 0, "R9 equal compares low wins");
    t_cascade();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule